// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is an eight-line general-purpose I/O port behind a byte-wide memory-mapped register interface. A direction register decides, pin by pin, whether the port drives the pad or listens to it. An output-value register feeds the pad drivers, and the direction bits serve directly as the output enables.

Data accesses do not need a read-modify-write. Any offset in the low kilobyte reaches the data register, and address bits [9:2] serve as a per-pin mask. A write updates only the pins whose mask bit is set. A read clears the unmasked pins to zero. Software can therefore flip one pin atomically with a single store to an offset that encodes that pin.

The seven interrupt configuration offsets are decoded here and handed to a separate interrupt unit as a one-hot select with write and read strobes. Reads of those offsets return that unit's data through the bank's registered read port.

Top module: `gpio_mask_bank`

## Requirements
- R1: After synchronous reset, all pins are inputs (pad_oe = 0x00), pad_out = 0x00 and rdata = 0x00.
- R2: Offset 0x400 holds the direction register. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. A write takes effect at the next clock edge, and the register reads back at 0x400.
- R3: A write to any offset 0x000–0x3FF updates output bit n only when address bit n+2 is 1. Every other output bit keeps its value.
- R4: A data write to a pin that is configured as input has no effect. The value must be written again after the pin becomes an output.
- R5: A read from offset 0x000–0x3FF returns 0 in bit n when address bit n+2 is 0, and returns the pin level when that bit is 1.
- R6: For an input pin, the level comes from a two-flop synchronizer on pad_in. A pad change is first returned by a read strobe held over the third rising edge after the change.
- R7: For an output pin, a read returns the driven value regardless of pad_in.
- R8: rdata is registered. It is updated at the edge where rd_en is high and holds its value while rd_en is low.
- R9: An access to offset 0x404 + 4k (k = 0..6) raises icfg_sel bit k and no other bit. icfg_wr is the same as wr_en and icfg_rd is the same as rd_en for those offsets, and icfg_wdata carries wdata. Other offsets give icfg_sel = 0.
- R10: A read of an interrupt configuration offset returns icfg_rdata one cycle later. A read of any undecoded offset, including an unaligned one near 0x400, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Output value to pads |
| pad_oe | output | 8 | Per-pin output enable |
| icfg_sel | output | 7 | One-hot select of interrupt configuration register |
| icfg_wr | output | 1 | Write strobe to interrupt unit |
| icfg_rd | output | 1 | Read strobe to interrupt unit |
| icfg_wdata | output | 8 | Write data to interrupt unit |
| icfg_rdata | input | 8 | Read data from interrupt unit |

## Verification
The masked data path is exercised with all-ones, single-bit, two-bit and empty address masks. With mixed directions, these patterns show whether a wrong bit was touched, whether an input pin accepted a write, and whether the read path returns the pad level or the driven value. A pad change with a held read strobe pins down the synchronizer depth, edge by edge. Walking the interrupt offsets shows whether the decode is off by one slot, and reads at neighbouring undecoded offsets show whether stray data leaks onto the bus.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  localparam int unsigned MB_ADDR_W  = 12;
  localparam logic [MB_ADDR_W-1:0] DIR_OFS   = 12'h400;
  localparam logic [MB_ADDR_W-1:0] ICFG_BASE = 12'h404;
  localparam int unsigned ICFG_COUNT = 7;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_DATA = 2'd1,
    HIT_DIR  = 2'd2,
    HIT_ICFG = 2'd3
  } hit_e;
endpackage

// File: rtl/gpio_mb_decode.sv
module gpio_mb_decode
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NICFG  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [NPINS-1:0]  mask,
  output logic [NICFG-1:0]  icfg_sel
);
  localparam int unsigned DATA_TOP = NPINS + 2;

  logic data_region;
  logic dir_match;

  assign mask        = addr[DATA_TOP-1:2];
  assign data_region = (addr[ADDR_W-1:DATA_TOP] == '0);
  assign dir_match   = (addr == ADDR_W'(DIR_OFS));

  for (genvar k = 0; k < NICFG; k++) begin : g_icfg
    assign icfg_sel[k] = (addr == ADDR_W'(ICFG_BASE) + ADDR_W'(4 * k));
  end

  always_comb begin
    if (data_region)      hit = HIT_DATA;
    else if (dir_match)   hit = HIT_DIR;
    else if (|icfg_sel)   hit = HIT_ICFG;
    else                  hit = HIT_NONE;
  end
endmodule

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mb_port.sv
module gpio_mb_port #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic             data_we,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        out_q[n] <= 1'b0;
      else if (data_we && mask[n] && dir_q[n])
        out_q[n] <= wdata[n];
    end
  end

  assert_masked_keep_R3: assert property (@(posedge clk) disable iff (rst)
    data_we |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));

  assert_input_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    data_we |=> ((out_q & ~$past(dir_q)) == ($past(out_q) & ~$past(dir_q))));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    dir_we |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = MB_ADDR_W,
  parameter int unsigned NICFG       = ICFG_COUNT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NICFG-1:0]  icfg_sel,
  output logic              icfg_wr,
  output logic              icfg_rd,
  output logic [NPINS-1:0]  icfg_wdata,
  input  logic [NPINS-1:0]  icfg_rdata
);
  hit_e             hit;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] rd_mux;
  logic [NPINS-1:0] rdata_q;

  gpio_mb_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W), .NICFG(NICFG)) u_dec (
    .addr     (addr),
    .hit      (hit),
    .mask     (mask),
    .icfg_sel (icfg_sel)
  );

  gpio_mb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  gpio_mb_port #(.NPINS(NPINS)) u_port (
    .clk     (clk),
    .rst     (rst),
    .dir_we  (wr_en && (hit == HIT_DIR)),
    .data_we (wr_en && (hit == HIT_DATA)),
    .mask    (mask),
    .wdata   (wdata),
    .dir_q   (dir_q),
    .out_q   (out_q)
  );

  assign level = (dir_q & out_q) | (~dir_q & pad_sync);

  always_comb begin
    unique case (hit)
      HIT_DATA: rd_mux = level & mask;
      HIT_DIR:  rd_mux = dir_q;
      HIT_ICFG: rd_mux = icfg_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata      = rdata_q;
  assign pad_out    = out_q;
  assign pad_oe     = dir_q;
  assign icfg_wr    = wr_en && (hit == HIT_ICFG);
  assign icfg_rd    = rd_en && (hit == HIT_ICFG);
  assign icfg_wdata = wdata;

  assert_read_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[ADDR_W-1:NPINS+2] == '0)) |=> ((rdata & ~$past(mask)) == '0));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(icfg_sel));

  assert_undecoded_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (hit == HIT_NONE)) |=> (rdata == '0));

  assert_output_readback_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (hit == HIT_DATA)) |=> ((rdata & $past(mask) & $past(dir_q)) ==
                                       ($past(out_q) & $past(mask) & $past(dir_q))));
endmodule

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [11:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pad_in = 8'hA5;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [6:0] icfg_sel;
  logic       icfg_wr;
  logic       icfg_rd;
  logic [7:0] icfg_wdata;
  logic [7:0] icfg_rdata = 8'h77;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_mask_bank uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .icfg_sel(icfg_sel), .icfg_wr(icfg_wr),
    .icfg_rd(icfg_rd), .icfg_wdata(icfg_wdata), .icfg_rdata(icfg_rdata)
  );

  // {is_read, offset, write data, expected read}
  localparam int NV = 18;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 12'h3FC, 8'hFF, 8'h00},  // input pins: write ignored
    {1'b1, 12'h400, 8'h00, 8'h00},
    {1'b0, 12'h400, 8'h0F, 8'h00},  // pins 0..3 output
    {1'b1, 12'h400, 8'h00, 8'h0F},
    {1'b0, 12'h3FC, 8'hFF, 8'h00},
    {1'b1, 12'h3FC, 8'h00, 8'hAF},  // outputs F, pad A on inputs
    {1'b0, 12'h008, 8'h00, 8'h00},  // only pin 1 cleared
    {1'b1, 12'h3FC, 8'h00, 8'hAD},
    {1'b1, 12'h00C, 8'h00, 8'h01},  // pins 0,1 visible
    {1'b1, 12'h000, 8'h00, 8'h00},  // empty mask
    {1'b0, 12'h400, 8'hFF, 8'h00},
    {1'b1, 12'h3FC, 8'h00, 8'h0D},  // earlier high-nibble write lost
    {1'b0, 12'h3FC, 8'hF0, 8'h00},
    {1'b1, 12'h3FC, 8'h00, 8'hF0},  // driven value, pad ignored
    {1'b0, 12'h200, 8'h00, 8'h00},  // only pin 7 cleared
    {1'b1, 12'h3FC, 8'h00, 8'h70},
    {1'b1, 12'h500, 8'h00, 8'h00},  // undecoded
    {1'b1, 12'h402, 8'h00, 8'h00}   // unaligned, undecoded
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] r);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    r = rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);

    // R3 R4 R5 R7 R10 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        do_read(VEC[i][27:16], r);
        check($sformatf("R5 table vec %0d", i), r, VEC[i][7:0]);
      end else begin
        do_write(VEC[i][27:16], VEC[i][15:8]);
      end
    end

    // R3 masked write seen at the pads
    check("R3 pad_out", pad_out, 8'h70);

    // R2 direction drives pad_oe
    do_write(12'h400, 8'h33);
    check("R2 pad_oe", pad_oe, 8'h33);
    do_read(12'h400, r);
    check("R2 readback", r, 8'h33);

    // R4 write to inputs, then rewrite after switching
    do_write(12'h400, 8'h00);
    do_write(12'h3FC, 8'hFF);
    check("R4 no effect", pad_out, 8'h70);
    do_write(12'h400, 8'hFF);
    do_write(12'h3FC, 8'hFF);
    check("R4 rewrite", pad_out, 8'hFF);

    // R6 synchronizer depth
    do_write(12'h400, 8'h00);
    @(negedge clk);
    pad_in = 8'h5A; addr = 12'h3FC; rd_en = 1'b1;
    @(negedge clk);
    check("R6 edge1", rdata, 8'hA5);
    @(negedge clk);
    check("R6 edge2", rdata, 8'hA5);
    @(negedge clk);
    check("R6 edge3", rdata, 8'h5A);
    rd_en = 1'b0;

    // R8 hold while idle
    pad_in = 8'h11;
    repeat (4) @(negedge clk);
    check("R8 hold", rdata, 8'h5A);

    // R9 interrupt decode
    @(negedge clk);
    addr = 12'h40C; wdata = 8'h3C; wr_en = 1'b1;
    #1;
    check("R9 sel 40C", {1'b0, icfg_sel}, 8'h04);
    check("R9 wr", {7'b0, icfg_wr}, 8'h01);
    check("R9 rd idle", {7'b0, icfg_rd}, 8'h00);
    check("R9 wdata", icfg_wdata, 8'h3C);
    @(negedge clk);
    wr_en = 1'b0; addr = 12'h41C; rd_en = 1'b1;
    #1;
    check("R9 sel 41C", {1'b0, icfg_sel}, 8'h40);
    check("R9 rd", {7'b0, icfg_rd}, 8'h01);
    @(negedge clk);
    rd_en = 1'b0; addr = 12'h404;
    #1;
    check("R9 sel 404", {1'b0, icfg_sel}, 8'h01);
    addr = 12'h400;
    #1;
    check("R9 sel none", {1'b0, icfg_sel}, 8'h00);
    check("R4 icfg write kept pins", pad_out, 8'hFF);

    // R10 interrupt read path
    do_read(12'h414, r);
    check("R10 icfg read", r, 8'h77);
    do_read(12'h420, r);
    check("R10 past last", r, 8'h00);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 oe after reset", pad_oe, 8'h00);
    check("R1 out after reset", pad_out, 8'h00);
    do_read(12'h400, r);
    check("R1 dir after reset", r, 8'h00);

    finish_run();
  end
endmodule